// File: doc/BRIEF.md
# Page Request Ring Writer

This block takes page-request messages from a device-side valid/ready port and stores each one as a 16-byte record in a circular ring in memory. The block owns the ring's tail index. Software owns the head index and supplies it as an input. Each record goes out as two 64-bit memory writes, low doubleword first. A global control bit can byte-swap each doubleword.

The block keeps two sticky error flags and an interrupt-pending flag:
- An overflow flag, set when a message arrives while the ring is full.
- A memory-fault flag, set when a record write faults.

A message is discarded when either error flag is set or when the queue is disabled. A discarded message that ends a request group, and is not a stop marker, produces an automatic group-response request on a separate valid/ready port. Any other discarded message is dropped silently.

The controller is a four-state machine:
- `ST_IDLE` accepts a message. It moves to `ST_WR_LO` when the record is to be written. It moves to `ST_RESP` for a discarded message that needs a reply. Otherwise it stays in `ST_IDLE`.
- `ST_WR_LO` writes the low doubleword. It moves to `ST_WR_HI` on a clean write. On a faulted write it moves to `ST_RESP` or `ST_IDLE`.
- `ST_WR_HI` writes the high doubleword. It returns to `ST_IDLE` and advances the tail on a clean write. On a fault it goes to `ST_RESP` or `ST_IDLE`.
- `ST_RESP` holds the response request until it is taken, then returns to `ST_IDLE`.

Top module: `pgreq_ring_writer`

## Requirements
- R1: After reset the tail is 0, both error flags and the interrupt flag are 0, `msg_ready` is 1, and neither `wr_valid` nor `rsp_valid` is asserted. `msg_ready` is 1 only in the idle state.
- R2: A recorded message produces exactly two write handshakes. The low doubleword goes to `ring_base + tail*16` and the high doubleword to `ring_base + tail*16 + 8`. The low doubleword holds:
  - the requester id in bits [23:0];
  - the PASID-valid bit in bit 32;
  - PRIV in bit 33 and EXEC in bit 34;
  - the PASID in bits [63:44];
  - zero in all other bits.
  The high doubleword is the 64-bit payload. Write backpressure only delays the writes.
- R3: When `big_endian` is 1, the bytes of each doubleword are reversed: byte k moves to byte 7-k.
- R4: When PASID-valid is 0, PRIV, EXEC and the PASID field are written as 0. When it is 1, they copy the message.
- R5: The tail advances by exactly 1 after the high doubleword is written without fault, and it wraps modulo the ring depth.
- R6: A message that arrives while recording is allowed and tail+1 equals head (mod depth) is not written, and it sets the overflow flag.
- R7: A write fault on either doubleword sets the memory-fault flag and leaves the tail unchanged. That message counts as discarded.
- R8: While either error flag is 1 or `q_en` is 0, no message is written.
- R9: A discarded message with the last-in-group flag (payload bit 2) at 0 produces no response.
- R10: A discarded message with the last-in-group flag at 1 and read (payload bit 0) or write (payload bit 1) set produces one response request. The response carries the requester id, PASID-valid, the PASID (0 when not valid) and the group index from payload bits [11:3].
- R11: A stop marker (last-in-group 1, read 0, write 0) that is discarded produces no response.
- R12: When `irq_en` is 1, the interrupt flag is set by a committed record or by either error flag being 1. `clr_irq` clears it when no set condition holds.
- R13: `clr_of` and `clr_mf` clear their flags by write-1-to-clear. Recording resumes only once both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| q_en | input | 1 | Queue enable |
| irq_en | input | 1 | Interrupt enable |
| big_endian | input | 1 | Byte-swap each record doubleword |
| ring_base | input | ADDR_W | Byte address of ring entry 0, 16-byte aligned |
| sw_head | input | IDX_W | Software head index |
| clr_of | input | 1 | Write-1-to-clear for the overflow flag |
| clr_mf | input | 1 | Write-1-to-clear for the memory-fault flag |
| clr_irq | input | 1 | Write-1-to-clear for the interrupt flag |
| msg_valid | input | 1 | Message valid |
| msg_ready | output | 1 | Message accepted this cycle when valid |
| msg_did | input | DID_W | Requester id |
| msg_pv | input | 1 | PASID present |
| msg_pid | input | PID_W | PASID |
| msg_priv | input | 1 | Privileged-mode requested |
| msg_exec | input | 1 | Execute requested |
| msg_payload | input | 64 | Message payload (bit0 read, bit1 write, bit2 last, [11:3] group) |
| wr_valid | output | 1 | Memory write request |
| wr_ready | input | 1 | Memory write accepted |
| wr_addr | output | ADDR_W | Write byte address |
| wr_data | output | 64 | Write doubleword |
| wr_fault | input | 1 | Fault on the accepted write, valid with the handshake |
| rsp_valid | output | 1 | Auto group-response request |
| rsp_ready | input | 1 | Response request taken |
| rsp_did | output | DID_W | Response requester id |
| rsp_pv | output | 1 | Response PASID present |
| rsp_pid | output | PID_W | Response PASID |
| rsp_grp | output | 9 | Response group index |
| hw_tail | output | IDX_W | Ring tail index |
| err_of | output | 1 | Overflow flag |
| err_mf | output | 1 | Memory-fault flag |
| irq_pend | output | 1 | Interrupt pending |

## Verification
The assertions assume that `wr_fault` is meaningful only during a write handshake. They also assume that `sw_head`, `q_en` and `big_endian` do not change while a message is in flight. The stimulus changes these controls only while the block is idle and waits between messages until every handshake has finished. Fault injection is tied to the address of the doubleword being written, so the fault lands on the chosen beat even under backpressure.

// File: rtl/pgreq_pkg.sv
package pgreq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WR_LO = 2'd1,
        ST_WR_HI = 2'd2,
        ST_RESP  = 2'd3
    } pgreq_state_e;

    // payload flag positions
    localparam int PL_RD_BIT  = 0;
    localparam int PL_WR_BIT  = 1;
    localparam int PL_LST_BIT = 2;
    localparam int PL_GRP_LSB = 3;
    localparam int GRP_W      = 9;

    // low record doubleword layout
    localparam int REC_DID_LSB  = 0;
    localparam int REC_PV_BIT   = 32;
    localparam int REC_PRIV_BIT = 33;
    localparam int REC_EXEC_BIT = 34;
    localparam int REC_PID_LSB  = 44;
endpackage

// File: rtl/pgreq_fmt.sv
module pgreq_fmt
    import pgreq_pkg::*;
#(
    parameter int DID_W = 24,
    parameter int PID_W = 20
) (
    input  logic [DID_W-1:0] did,
    input  logic             pv,
    input  logic [PID_W-1:0] pid,
    input  logic             priv,
    input  logic             exec,
    input  logic [63:0]      payload,
    input  logic             be,
    output logic [63:0]      dw_lo,
    output logic [63:0]      dw_hi
);
    localparam int NBYTES = 8;

    logic [63:0] raw_lo;
    logic [63:0] swp_lo;
    logic [63:0] swp_hi;

    always_comb begin
        raw_lo = '0;
        raw_lo[REC_DID_LSB +: DID_W] = did;
        raw_lo[REC_PV_BIT]           = pv;
        raw_lo[REC_PRIV_BIT]         = pv & priv;
        raw_lo[REC_EXEC_BIT]         = pv & exec;
        raw_lo[REC_PID_LSB +: PID_W] = pv ? pid : '0;
    end

    for (genvar b = 0; b < NBYTES; b++) begin : g_swap
        assign swp_lo[8*b +: 8] = raw_lo[8*(NBYTES-1-b) +: 8];
        assign swp_hi[8*b +: 8] = payload[8*(NBYTES-1-b) +: 8];
    end

    assign dw_lo = be ? swp_lo : raw_lo;
    assign dw_hi = be ? swp_hi : payload;
endmodule

// File: rtl/pgreq_ring.sv
module pgreq_ring #(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic [IDX_W-1:0] head,
    output logic [IDX_W-1:0] tail,
    output logic             full
);
    logic [IDX_W-1:0] tail_inc;

    assign tail_inc = tail + {{(IDX_W-1){1'b0}}, 1'b1};
    assign full     = (tail_inc == head);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       tail <= '0;
        else if (advance) tail <= tail_inc;
    end
endmodule

// File: rtl/pgreq_ring_writer.sv
module pgreq_ring_writer
    import pgreq_pkg::*;
#(
    parameter int ADDR_W = 40,
    parameter int IDX_W  = 4,
    parameter int DID_W  = 24,
    parameter int PID_W  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              q_en,
    input  logic              irq_en,
    input  logic              big_endian,
    input  logic [ADDR_W-1:0] ring_base,
    input  logic [IDX_W-1:0]  sw_head,
    input  logic              clr_of,
    input  logic              clr_mf,
    input  logic              clr_irq,
    input  logic              msg_valid,
    output logic              msg_ready,
    input  logic [DID_W-1:0]  msg_did,
    input  logic              msg_pv,
    input  logic [PID_W-1:0]  msg_pid,
    input  logic              msg_priv,
    input  logic              msg_exec,
    input  logic [63:0]       msg_payload,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [63:0]       wr_data,
    input  logic              wr_fault,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [DID_W-1:0]  rsp_did,
    output logic              rsp_pv,
    output logic [PID_W-1:0]  rsp_pid,
    output logic [GRP_W-1:0]  rsp_grp,
    output logic [IDX_W-1:0]  hw_tail,
    output logic              err_of,
    output logic              err_mf,
    output logic              irq_pend
);
    localparam int PAD_W = ADDR_W - IDX_W - 4;

    pgreq_state_e state, nxt;

    logic [DID_W-1:0] l_did;
    logic             l_pv, l_priv, l_exec;
    logic [PID_W-1:0] l_pid;
    logic [63:0]      l_pl;

    logic        full, blocked, acc, wr_hs;
    logic        in_need_rsp, l_need_rsp;
    logic        set_of, set_mf, advance, sel_hi;
    logic [63:0] dw_lo, dw_hi;

    pgreq_ring #(.IDX_W(IDX_W)) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (advance),
        .head    (sw_head),
        .tail    (hw_tail),
        .full    (full)
    );

    pgreq_fmt #(.DID_W(DID_W), .PID_W(PID_W)) u_fmt (
        .did     (l_did),
        .pv      (l_pv),
        .pid     (l_pid),
        .priv    (l_priv),
        .exec    (l_exec),
        .payload (l_pl),
        .be      (big_endian),
        .dw_lo   (dw_lo),
        .dw_hi   (dw_hi)
    );

    assign blocked     = !q_en || err_of || err_mf;
    assign acc         = msg_valid && (state == ST_IDLE);
    assign wr_hs       = wr_valid && wr_ready;
    assign in_need_rsp = msg_payload[PL_LST_BIT] && (msg_payload[PL_RD_BIT] || msg_payload[PL_WR_BIT]);
    assign l_need_rsp  = l_pl[PL_LST_BIT] && (l_pl[PL_RD_BIT] || l_pl[PL_WR_BIT]);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state and outputs
    always_comb begin
        nxt       = state;
        msg_ready = 1'b0;
        wr_valid  = 1'b0;
        sel_hi    = 1'b0;
        rsp_valid = 1'b0;
        set_of    = 1'b0;
        set_mf    = 1'b0;
        advance   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                msg_ready = 1'b1;
                if (acc) begin
                    if (blocked || full) begin
                        set_of = !blocked;
                        nxt    = in_need_rsp ? ST_RESP : ST_IDLE;
                    end else begin
                        nxt = ST_WR_LO;
                    end
                end
            end
            ST_WR_LO: begin
                wr_valid = 1'b1;
                if (wr_hs) begin
                    if (wr_fault) begin
                        set_mf = 1'b1;
                        nxt    = l_need_rsp ? ST_RESP : ST_IDLE;
                    end else begin
                        nxt = ST_WR_HI;
                    end
                end
            end
            ST_WR_HI: begin
                wr_valid = 1'b1;
                sel_hi   = 1'b1;
                if (wr_hs) begin
                    if (wr_fault) begin
                        set_mf = 1'b1;
                        nxt    = l_need_rsp ? ST_RESP : ST_IDLE;
                    end else begin
                        advance = 1'b1;
                        nxt     = ST_IDLE;
                    end
                end
            end
            ST_RESP: begin
                rsp_valid = 1'b1;
                if (rsp_ready) nxt = ST_IDLE;
            end
        endcase
    end

    // message latch, status flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l_did    <= '0;
            l_pv     <= 1'b0;
            l_pid    <= '0;
            l_priv   <= 1'b0;
            l_exec   <= 1'b0;
            l_pl     <= '0;
            err_of   <= 1'b0;
            err_mf   <= 1'b0;
            irq_pend <= 1'b0;
        end else begin
            if (acc) begin
                l_did  <= msg_did;
                l_pv   <= msg_pv;
                l_pid  <= msg_pid;
                l_priv <= msg_priv;
                l_exec <= msg_exec;
                l_pl   <= msg_payload;
            end
            err_of   <= set_of | (err_of & ~clr_of);
            err_mf   <= set_mf | (err_mf & ~clr_mf);
            irq_pend <= (irq_en & (err_of | err_mf | advance)) | (irq_pend & ~clr_irq);
        end
    end

    assign wr_addr = ring_base + {{PAD_W{1'b0}}, hw_tail, sel_hi, 3'b000};
    assign wr_data = sel_hi ? dw_hi : dw_lo;
    assign rsp_did = l_did;
    assign rsp_pv  = l_pv;
    assign rsp_pid = l_pv ? l_pid : '0;
    assign rsp_grp = l_pl[PL_GRP_LSB +: GRP_W];

    assert_ready_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        msg_ready |-> (!wr_valid && !rsp_valid));

    assert_tail_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_tail != $past(hw_tail)) |-> (hw_tail == $past(hw_tail) + 1'b1));

    assert_full_sets_of_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_ready && !blocked && full) |=> (err_of && !wr_valid));

    assert_fault_sets_mf_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready && wr_fault) |=> (err_mf && $stable(hw_tail)));

    assert_blocked_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_ready && blocked) |=> !wr_valid);

    assert_stop_no_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (l_pl[PL_LST_BIT] && (l_pl[PL_RD_BIT] || l_pl[PL_WR_BIT])));

    assert_irq_on_error_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en && (err_of || err_mf)) |=> irq_pend);
endmodule

// File: tb/test_pgreq_ring_writer.sv
module test_pgreq_ring_writer;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;
    localparam logic [39:0] BASE = 40'h12_3450_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic q_en = 1'b0, irq_en = 1'b0, big_endian = 1'b0;
    logic [3:0] sw_head = '0;
    logic clr_of = 1'b0, clr_mf = 1'b0, clr_irq = 1'b0;
    logic msg_valid = 1'b0, msg_ready;
    logic [23:0] msg_did = '0;
    logic msg_pv = 1'b0, msg_priv = 1'b0, msg_exec = 1'b0;
    logic [19:0] msg_pid = '0;
    logic [63:0] msg_payload = '0;
    logic wr_valid, wr_fault;
    logic wr_rdy = 1'b1;
    logic [39:0] wr_addr;
    logic [63:0] wr_data;
    logic rsp_valid;
    logic [23:0] rsp_did;
    logic rsp_pv;
    logic [19:0] rsp_pid;
    logic [8:0] rsp_grp;
    logic [3:0] hw_tail;
    logic err_of, err_mf, irq_pend;

    int fault_sel = 0;
    bit stall = 1'b0;
    bit cmp_on = 1'b0;
    int n_chk = 0, n_fail = 0;
    int m_tail = 0;
    bit m_of = 0, m_mf = 0, m_irq = 0;

    logic [39:0] wa_q[$];
    logic [63:0] wd_q[$];
    logic [23:0] rd_q[$];
    logic        rp_q[$];
    logic [19:0] ri_q[$];
    logic [8:0]  rg_q[$];

    assign wr_fault = (fault_sel == 1 && !wr_addr[3]) || (fault_sel == 2 && wr_addr[3]);

    always #(CLK_PERIOD/2) clk = ~clk;

    pgreq_ring_writer i_pgreq_ring_writer (
        .clk(clk), .rst_n(rst_n), .q_en(q_en), .irq_en(irq_en), .big_endian(big_endian),
        .ring_base(BASE), .sw_head(sw_head), .clr_of(clr_of), .clr_mf(clr_mf), .clr_irq(clr_irq),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_did(msg_did), .msg_pv(msg_pv),
        .msg_pid(msg_pid), .msg_priv(msg_priv), .msg_exec(msg_exec), .msg_payload(msg_payload),
        .wr_valid(wr_valid), .wr_ready(wr_rdy), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_fault(wr_fault), .rsp_valid(rsp_valid), .rsp_ready(1'b1), .rsp_did(rsp_did),
        .rsp_pv(rsp_pv), .rsp_pid(rsp_pid), .rsp_grp(rsp_grp), .hw_tail(hw_tail),
        .err_of(err_of), .err_mf(err_mf), .irq_pend(irq_pend)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst_n && wr_valid && wr_rdy) begin
            wa_q.push_back(wr_addr);
            wd_q.push_back(wr_data);
        end
        if (rst_n && rsp_valid) begin
            rd_q.push_back(rsp_did);
            rp_q.push_back(rsp_pv);
            ri_q.push_back(rsp_pid);
            rg_q.push_back(rsp_grp);
        end
    end

    always @(negedge clk) wr_rdy <= stall ? ~wr_rdy : 1'b1;

    // status compared every idle clock against the model
    always @(negedge clk) begin
        if (cmp_on) begin
            chk(hw_tail == 4'(m_tail), "R5 tail", 64'(hw_tail), 64'(m_tail));
            chk(err_of == m_of, "R6 err_of", 64'(err_of), 64'(m_of));
            chk(err_mf == m_mf, "R7 err_mf", 64'(err_mf), 64'(m_mf));
            chk(irq_pend == m_irq, "R12 irq_pend", 64'(irq_pend), 64'(m_irq));
        end
    end

    function automatic logic [63:0] swap8(input logic [63:0] x);
        logic [63:0] y;
        for (int b = 0; b < 8; b++) y[8*b +: 8] = x[8*(7-b) +: 8];
        return y;
    endfunction

    function automatic logic [63:0] mkpl(input logic [51:0] up, input logic [8:0] grp,
                                         input logic l, input logic w, input logic r);
        return {up, grp, l, w, r};
    endfunction

    task automatic settle();
        repeat (2) @(negedge clk);
        m_irq = m_irq | (irq_en && (m_of || m_mf));
        cmp_on = 1'b1;
    endtask

    task automatic set_ctrl(input logic en, input logic ie, input logic be, input logic [3:0] hd);
        cmp_on = 1'b0;
        q_en = en; irq_en = ie; big_endian = be; sw_head = hd;
        settle();
    endtask

    task automatic pulse_clr(input logic cof, input logic cmf, input logic cirq);
        bit old_err;
        cmp_on = 1'b0;
        old_err = m_of || m_mf;
        clr_of = cof; clr_mf = cmf; clr_irq = cirq;
        @(negedge clk);
        clr_of = 1'b0; clr_mf = 1'b0; clr_irq = 1'b0;
        if (cof) m_of = 0;
        if (cmf) m_mf = 0;
        if (cirq) m_irq = irq_en && old_err;
        settle();
    endtask

    task automatic run_msg(input logic [23:0] did, input logic pv, input logic [19:0] pid,
                           input logic priv, input logic ex, input logic [63:0] pl,
                           input int fsel, input string tag);
        bit blk, full, rec, commit, discard, need;
        int nexp;
        logic [63:0] elo, ehi;
        cmp_on = 1'b0;
        wa_q.delete(); wd_q.delete(); rd_q.delete(); rp_q.delete(); ri_q.delete(); rg_q.delete();
        fault_sel = fsel;
        msg_did = did; msg_pv = pv; msg_pid = pid; msg_priv = priv; msg_exec = ex; msg_payload = pl;
        msg_valid = 1'b1;
        while (!msg_ready) @(negedge clk);
        @(negedge clk);
        msg_valid = 1'b0;
        repeat (12) @(negedge clk);
        fault_sel = 0;

        // reference model
        blk = !q_en || m_of || m_mf;
        full = (((m_tail + 1) % DEPTH) == int'(sw_head));
        rec = 0; commit = 0; nexp = 0;
        if (!blk) begin
            if (full) m_of = 1;
            else rec = 1;
        end
        if (rec) begin
            if (fsel == 1) begin nexp = 1; m_mf = 1; end
            else if (fsel == 2) begin nexp = 2; m_mf = 1; end
            else begin nexp = 2; commit = 1; end
        end
        discard = !commit;
        need = discard && pl[2] && (pl[0] || pl[1]);
        elo = '0;
        elo[23:0] = did;
        elo[32] = pv;
        elo[33] = pv & priv;
        elo[34] = pv & ex;
        elo[63:44] = pv ? pid : 20'h0;
        ehi = pl;
        if (big_endian) begin elo = swap8(elo); ehi = swap8(ehi); end

        chk(wa_q.size() == nexp, {tag, " R2/R8 write count"}, 64'(wa_q.size()), 64'(nexp));
        if (wa_q.size() == nexp) begin
            for (int i = 0; i < nexp; i++) begin
                chk(wa_q[i] == BASE + 40'(m_tail * 16 + i * 8), {tag, " R2 addr"},
                    64'(wa_q[i]), 64'(BASE + 40'(m_tail * 16 + i * 8)));
                chk(wd_q[i] == (i == 0 ? elo : ehi), {tag, " R2/R3/R4 data"},
                    wd_q[i], (i == 0 ? elo : ehi));
            end
        end
        chk(rd_q.size() == (need ? 1 : 0), {tag, " R9/R10/R11 rsp count"},
            64'(rd_q.size()), 64'(need ? 1 : 0));
        if (need && rd_q.size() == 1) begin
            chk(rd_q[0] == did, {tag, " R10 rsp did"}, 64'(rd_q[0]), 64'(did));
            chk(rp_q[0] == pv, {tag, " R10 rsp pv"}, 64'(rp_q[0]), 64'(pv));
            chk(ri_q[0] == (pv ? pid : 20'h0), {tag, " R10 rsp pid"}, 64'(ri_q[0]), 64'(pv ? pid : 20'h0));
            chk(rg_q[0] == pl[11:3], {tag, " R10 rsp grp"}, 64'(rg_q[0]), 64'(pl[11:3]));
        end
        if (commit) m_tail = (m_tail + 1) % DEPTH;
        m_irq = m_irq | (irq_en && (m_of || m_mf || commit));
        cmp_on = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(msg_ready == 1'b1, "R1 msg_ready", 64'(msg_ready), 64'd1);
        chk(!wr_valid && !rsp_valid, "R1 no requests", 64'({wr_valid, rsp_valid}), 64'd0);
        chk(hw_tail == 4'd0, "R1 tail", 64'(hw_tail), 64'd0);
        chk(!err_of && !err_mf && !irq_pend, "R1 flags", 64'({err_of, err_mf, irq_pend}), 64'd0);
        cmp_on = 1'b1;

        set_ctrl(1'b1, 1'b0, 1'b0, 4'd0);
        run_msg(24'hA1B2C3, 1'b1, 20'hF00D5, 1'b1, 1'b1, mkpl(52'h1234_5678_9ABC_D, 9'h055, 1, 0, 1), 0, "R2 rec pv");
        run_msg(24'h000777, 1'b0, 20'hFFFFF, 1'b1, 1'b1, mkpl(52'hDEAD_BEEF_0000_1, 9'h1FF, 0, 1, 0), 0, "R4 mask");
        set_ctrl(1'b1, 1'b0, 1'b1, 4'd0);
        run_msg(24'h010203, 1'b1, 20'h0A0B0, 1'b0, 1'b1, mkpl(52'h0011_2233_4455_6, 9'h003, 1, 1, 1), 0, "R3 swap");
        set_ctrl(1'b1, 1'b0, 1'b0, 4'd0);
        stall = 1'b1;
        run_msg(24'h00BEEF, 1'b1, 20'h12345, 1'b0, 1'b0, mkpl(52'h0, 9'h100, 0, 0, 1), 0, "R2 stall");
        stall = 1'b0;
        set_ctrl(1'b1, 1'b1, 1'b0, 4'd0);
        run_msg(24'h000042, 1'b0, 20'h0, 1'b0, 0, mkpl(52'h5, 9'h001, 0, 1, 1), 0, "R12 commit");
        pulse_clr(1'b0, 1'b0, 1'b1);
        // fill up to tail 15 (R5)
        while (m_tail != 15) run_msg(24'(m_tail), 1'b0, 20'h0, 1'b0, 1'b0, mkpl(52'(m_tail), 9'h0, 0, 0, 1), 0, "R5 fill");
        // full ring (R6, R10)
        run_msg(24'h0FACE0, 1'b1, 20'h00ABC, 1'b0, 1'b0, mkpl(52'h7, 9'h0AA, 1, 0, 1), 0, "R6 full");
        run_msg(24'h000111, 1'b1, 20'h00001, 1'b0, 1'b0, mkpl(52'h8, 9'h011, 0, 1, 1), 0, "R9 silent");
        run_msg(24'h000222, 1'b1, 20'h00002, 1'b0, 1'b0, mkpl(52'h9, 9'h022, 1, 0, 0), 0, "R11 stop");
        pulse_clr(1'b1, 1'b0, 1'b0);
        set_ctrl(1'b1, 1'b1, 1'b0, 4'd8);
        run_msg(24'h000333, 1'b0, 20'h0, 1'b0, 1'b0, mkpl(52'hA, 9'h033, 0, 0, 1), 0, "R13 resume wrap");
        // faults (R7)
        run_msg(24'h000444, 1'b0, 20'h77777, 1'b1, 1'b1, mkpl(52'hB, 9'h044, 1, 1, 0), 1, "R7 lo fault");
        pulse_clr(1'b1, 1'b0, 1'b0);
        run_msg(24'h000555, 1'b1, 20'h00555, 1'b0, 1'b0, mkpl(52'hC, 9'h055, 1, 1, 0), 0, "R13 still blocked");
        pulse_clr(1'b0, 1'b1, 1'b0);
        pulse_clr(1'b0, 1'b0, 1'b1);
        run_msg(24'h000666, 1'b1, 20'h00666, 1'b1, 1'b0, mkpl(52'hD, 9'h066, 0, 0, 1), 0, "R13 resumed");
        run_msg(24'h000888, 1'b1, 20'h00888, 1'b0, 1'b0, mkpl(52'hE, 9'h088, 1, 0, 1), 2, "R7 hi fault");
        pulse_clr(1'b0, 1'b1, 1'b0);
        pulse_clr(1'b0, 1'b0, 1'b1);
        // disabled queue (R8)
        set_ctrl(1'b0, 1'b1, 1'b0, 4'd8);
        run_msg(24'h000999, 1'b0, 20'h0, 1'b0, 1'b0, mkpl(52'hF, 9'h099, 1, 0, 1), 0, "R8 disabled");
        run_msg(24'h000AAA, 1'b0, 20'h0, 1'b0, 1'b0, mkpl(52'hF, 9'h0AA, 0, 0, 1), 0, "R8 disabled silent");
        set_ctrl(1'b1, 1'b1, 1'b0, 4'd8);
        run_msg(24'h000BBB, 1'b1, 20'h0BBBB, 1'b1, 1'b1, mkpl(52'h10, 9'h0BB, 1, 1, 1), 0, "R8 reenabled");
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule